// File: doc/BRIEF.md
# Indexed-Color Pixel Rate Adapter

This block sits between a retro video generator and a full-rate display pipeline. The generator produces a new 4-bit palette index, together with horizontal and vertical sync, once every second clock, and it marks each update with a pixel-enable strobe. The display side accepts one 24-bit RGB pixel with its syncs on every clock.

The block captures the index and both syncs together when the strobe is high. It expands the index to 8-bit red, green and blue through a fixed 16-color palette and presents each pixel for two consecutive clocks. The syncs are delayed through the same register stages as the color, so all outputs change on the same edge. A data-valid output marks the clocks that carry picture data. While either sync is active, the color is blanked to zero. An active picture of up to 320 by 200 pixels passes through unchanged. Clock-domain crossing and the display encoder lie outside the block.

Top module: `pix_rate_adapter`

## Requirements
- R1: While rst_ni is low, and after its release until the first captured pixel reaches the outputs, rgb_o, hsync_o, vsync_o and de_o are all zero.
- R2: idx_i, hsync_i and vsync_i are sampled only on a rising clock edge where pix_en_i is 1. Their values at other edges have no effect on any output.
- R3: A pixel captured at edge k drives rgb_o, hsync_o, vsync_o and de_o from edge k+1 onward, with all four changing on the same edge.
- R4: Each captured pixel is presented for exactly two clocks, from edge k+1 through edge k+2. If no new pixel is captured, de_o and rgb_o return to zero at edge k+3, and hsync_o and vsync_o keep the last captured values.
- R5: The palette maps index bits [2], [1] and [0] to the red, green and blue channels, and index bit [3] to intensity. A channel whose bit is set reads 8'hFF when bit 3 is 1 and 8'hAA when bit 3 is 0. A channel whose bit is clear reads 8'h55 when bit 3 is 1 and 8'h00 when bit 3 is 0. rgb_o is {red, green, blue}.
- R6: Both syncs are active high. During a presented pixel whose captured hsync or vsync is 1, rgb_o is zero and de_o is 0.
- R7: With pix_en_i pulsed on every second clock, de_o stays high without gaps for non-blanked pixels, and each pixel occupies exactly two consecutive output clocks in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Output pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Generator update strobe |
| idx_i | input | 4 | Palette index from the generator |
| hsync_i | input | 1 | Horizontal sync from the generator, active high |
| vsync_i | input | 1 | Vertical sync from the generator, active high |
| rgb_o | output | 24 | Expanded color {red, green, blue} |
| hsync_o | output | 1 | Horizontal sync aligned with rgb_o |
| vsync_o | output | 1 | Vertical sync aligned with rgb_o |
| de_o | output | 1 | Data valid for the current output pixel |

## Verification
The hardest case to reach from the ports is the second output clock of a pixel while a new pixel is being captured on the same edge. There, the capture register already holds the next value, but the outputs must still show the previous one. The stimulus drives a gapless stream with the strobe on every second clock and checks both output clocks of each pixel. It also changes idx_i and the syncs while the strobe is low, so that any sampling outside the strobe shows up on the outputs.

// File: rtl/pra_pkg.sv
package pra_pkg;
  localparam int IDX_W  = 4;
  localparam int CHAN_W = 8;
  localparam int NCHAN  = 3;
  localparam int RGB_W  = CHAN_W * NCHAN;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             hs;
    logic             vs;
  } pix_t;

  // one channel of the fixed palette: on/off bit plus intensity bit
  function automatic logic [CHAN_W-1:0] chan_level(input logic on, input logic bright);
    case ({on, bright})
      2'b11:   chan_level = 8'hFF;
      2'b10:   chan_level = 8'hAA;
      2'b01:   chan_level = 8'h55;
      default: chan_level = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pra_capture.sv
module pra_capture
  import pra_pkg::*;
#(
  parameter int REPEAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pix_en_i,
  input  pix_t pix_i,
  output pix_t pix_o,
  output logic live_o
);
  localparam int CNT_W = $clog2(REPEAT + 1);

  pix_t             pix_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      cnt_q <= '0;
    end else if (pix_en_i) begin
      pix_q <= pix_i;
      cnt_q <= CNT_W'(REPEAT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pix_o  = pix_q;
  assign live_o = (cnt_q != '0);

  assert_capture_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_i |=> live_o);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(pix_o));
endmodule

// File: rtl/pra_palette.sv
module pra_palette
  import pra_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pix_t             pix_i,
  input  logic             live_i,
  output logic [RGB_W-1:0] rgb_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o
);
  logic [RGB_W-1:0] rgb_d;
  logic             blank;
  logic             de_d;

  assign blank = pix_i.hs | pix_i.vs;
  assign de_d  = live_i & ~blank;

  // channel n takes index bit (NCHAN-1-n): red = bit 2, blue = bit 0
  for (genvar n = 0; n < NCHAN; n++) begin : g_chan
    assign rgb_d[RGB_W-1-n*CHAN_W -: CHAN_W] =
      de_d ? chan_level(pix_i.idx[NCHAN-1-n], pix_i.idx[IDX_W-1]) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o   <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
    end else begin
      rgb_o   <= rgb_d;
      hsync_o <= pix_i.hs;
      vsync_o <= pix_i.vs;
      de_o    <= de_d;
    end
  end

  assert_blank_rgb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (rgb_o == '0));
  assert_de_no_sync_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> !(hsync_o || vsync_o));
endmodule

// File: rtl/pix_rate_adapter.sv
module pix_rate_adapter
  import pra_pkg::*;
#(
  parameter int REPEAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  output logic [RGB_W-1:0] rgb_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o
);
  pix_t pix_in, pix_cap;
  logic live;

  assign pix_in = '{idx: idx_i, hs: hsync_i, vs: vsync_i};

  pra_capture #(.REPEAT(REPEAT)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pix_en_i(pix_en_i),
    .pix_i   (pix_in),
    .pix_o   (pix_cap),
    .live_o  (live)
  );

  pra_palette u_palette (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pix_i  (pix_cap),
    .live_i (live),
    .rgb_o  (rgb_o),
    .hsync_o(hsync_o),
    .vsync_o(vsync_o),
    .de_o   (de_o)
  );

  // cycles since reset, saturating, so $past never reaches into reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 1'b1;
  end

  assert_sync_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(pix_en_i, 2) && !$past(pix_en_i, 1)) |->
      (hsync_o == $past(hsync_i, 2) && vsync_o == $past(vsync_i, 2)));
  assert_de_on_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && $past(pix_en_i) && !$past(hsync_i) && !$past(vsync_i)) |=> de_o);
  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd0) |-> (!de_o && rgb_o == '0));
endmodule

// File: tb/pix_rate_adapter_test.sv
module pix_rate_adapter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic [3:0]  idx = '0;
  logic        hs = 1'b0, vs = 1'b0;
  logic [23:0] rgb;
  logic        hs_o, vs_o, de;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pix_rate_adapter uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .idx_i(idx),
    .hsync_i(hs), .vsync_i(vs), .rgb_o(rgb), .hsync_o(hs_o),
    .vsync_o(vs_o), .de_o(de)
  );

  // vector = {idx, hs, vs}
  localparam logic [5:0] VEC [0:11] = '{
    6'b0000_00, 6'b1111_00, 6'b0111_00, 6'b1000_00,
    6'b1010_00, 6'b0101_00, 6'b1100_00, 6'b0011_00,
    6'b1001_10, 6'b0110_01, 6'b1111_11, 6'b0100_00
  };

  function automatic logic [7:0] lvl(input logic on, input logic br);
    if (on) return br ? 8'hFF : 8'hAA;
    return br ? 8'h55 : 8'h00;
  endfunction

  // expected {de, hs, vs, rgb} for a presented vector (R5, R6)
  function automatic logic [26:0] exp_of(input logic [5:0] v);
    logic [3:0] i;
    logic bl;
    i  = v[5:2];
    bl = v[1] | v[0];
    if (bl) return {1'b0, v[1], v[0], 24'h0};
    return {1'b1, v[1], v[0], lvl(i[2], i[3]), lvl(i[1], i[3]), lvl(i[0], i[3])};
  endfunction

  task automatic chk(input string req, input logic [26:0] exp);
    n_chk++;
    if ({de, hs_o, vs_o, rgb} !== exp) begin
      n_fail++;
      $display("FAIL %s: got de=%b hs=%b vs=%b rgb=%h, expected de=%b hs=%b vs=%b rgb=%h",
               req, de, hs_o, vs_o, rgb, exp[26], exp[25], exp[24], exp[23:0]);
    end
  endtask

  task automatic drive(input logic en, input logic [5:0] v);
    pix_en = en; idx = v[5:2]; hs = v[1]; vs = v[0];
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 in reset", 27'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 27'h0);

    // table walk: R2, R3, R4, R5, R6
    for (int k = 0; k < 12; k++) begin
      drive(1'b1, VEC[k]);
      @(negedge clk);
      drive(1'b0, ~VEC[k]);              // R2: values without strobe are ignored
      chk("R3 not before k+1", k == 0 ? 27'h0 : {3'b0, VEC[k-1][1:0], 24'h0} >> 0);
      @(negedge clk);
      drive(1'b0, {VEC[k][5:2] ^ 4'h5, 2'b11});
      chk("R5/R6 first clock", exp_of(VEC[k]));
      @(negedge clk);
      chk("R4/R2 second clock", exp_of(VEC[k]));
      @(negedge clk);
      chk("R4 idle after two", {3'b0, VEC[k][1], VEC[k][0], 24'h0});
    end

    // R7: gapless stream, strobe every second clock
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, VEC[k]);
      @(negedge clk);
      if (k > 0) chk("R7 prev second clock", exp_of(VEC[k-1]));
      drive(1'b0, 6'b0);
      @(negedge clk);
      chk("R7 first clock", exp_of(VEC[k]));
    end
    @(negedge clk);
    chk("R7 last second clock", exp_of(VEC[5]));
    @(negedge clk);
    chk("R4 idle after stream", {3'b0, VEC[5][1:0], 24'h0});

    // R1: reset mid-pixel
    drive(1'b1, 6'b1111_00);
    @(negedge clk);
    drive(1'b0, 6'b0);
    @(negedge clk);
    chk("R5 before reset", exp_of(6'b1111_00));
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", 27'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 no stale pixel", 27'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule